// File: doc/BRIEF.md
# I2C Write Master with Acknowledge-Failure Lock

This block is an I2C master that only writes. Software or a DMA engine writes bytes into a one-entry holding register over a small register bus. When the engine is idle, the first byte written starts a transfer: a START condition, the target address with the write bit, then data bytes with the most significant bit first. A byte written while the previous one is still being shifted out continues the same transfer. When the holding register is empty, the block raises a ready flag, and the same flag drives the DMA request pin.

If the target leaves SDA high in an acknowledge slot, the block abandons the transfer. In one clock cycle it sets the acknowledge-failure flag, the transfer-complete flag and the ready flag, and then it drives a STOP. With the lock option enabled, the failure also locks the holding register. While the lock is set, a DMA write into the holding register is swallowed and nothing reaches the bus. Software clears the lock through a command register.

Top module: `i2c_tx_master`

Register map (3-bit address): 0 = config (`[6:0]` target address, `[7]` lock option), 1 = divider (SCL quarter period minus one, in clocks), 2 = holding register (write), 3 = status (read; `[0]` ready, `[1]` complete, `[2]` ack-failure, `[3]` locked), 4 = interrupt enable (same bit positions as status), 5 = command (write `[0]`=1 to unlock).

## Requirements
- R1: After reset, status reads 0x03 (ready and complete set, ack-failure and locked clear), SCL and SDA are released, and irq is low.
- R2: A write to address 2 while idle and unlocked produces one START, the address byte `{addr,0}`, the data byte MSB first, a STOP once the last byte is acknowledged, and then status 0x03.
- R3: A byte written while ready is high during a transfer goes out in the same transfer, after the previous byte, with no new START.
- R4: dma_req equals status bit 0 (ready). It drops in the cycle after a holding-register write and returns once the byte has been taken.
- R5: An acknowledge failure sets status bits 2, 1 and 0 in the same clock cycle, and any byte still in the holding register is discarded.
- R6: After an acknowledge failure the block drives a STOP and returns to idle with both lines released.
- R7: With config bit 7 set, an acknowledge failure also sets status bit 3 (locked).
- R8: While locked, a write to address 2 produces no START, and ready stays high.
- R9: Writing 1 to command bit 0 clears locked. The next holding-register write then starts a normal transfer.
- R10: With config bit 7 clear, nothing locks, and a write after a failure starts a fresh transfer with START and address.
- R11: Status flags stay pending whatever the interrupt enables hold. A status read clears the ack-failure flag from the next cycle on.
- R12: irq is high exactly when some status bit and its enable bit at address 4 are both set.
- R13: During address and data bits, SDA changes only while SCL is low. START and STOP are the only SDA changes while SCL is high.
- R14: Each SCL high phase during a byte lasts 2*(D+1) clocks, where D is the divider value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read has a side effect) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Masked OR of the status flags |
| dma_req | output | 1 | Request for the next byte (mirrors ready) |

## Verification
Register effects are due at the first rising edge after the strobe, so the bench drives strobes just after a falling edge and reads the result at the next falling edge. Bus results depend on the divider: a quarter SCL period lasts D+1 clocks, and a transfer needs 36 quarters per byte plus START and STOP. The bench therefore waits on the STOP count of a bus model that acts as the target, with a bounded wait, before it compares received bytes and flags. The one-cycle coincidence of the three failure flags is checked at the ports: on the first cycle irq rises with only ack-failure enabled, dma_req must already be high.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 3;
    localparam int FLAG_N = 4;
    localparam int TADR_W = 7;
    localparam int BIT_IW = $clog2(BYTE_W + 1);
    // the ninth slot of every byte carries the acknowledge
    localparam logic [BIT_IW-1:0] ACK_IDX = BIT_IW'(BYTE_W);

    localparam logic [REG_AW-1:0] RA_CFG  = 3'd0;
    localparam logic [REG_AW-1:0] RA_DIV  = 3'd1;
    localparam logic [REG_AW-1:0] RA_DATA = 3'd2;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd3;
    localparam logic [REG_AW-1:0] RA_IEN  = 3'd4;
    localparam logic [REG_AW-1:0] RA_CMD  = 3'd5;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_START,
        EN_SHIFT,
        EN_STOP
    } eng_state_t;

    // packed MSB first: locked lands on bit 3, tx_ready on bit 0
    typedef struct packed {
        logic locked;
        logic no_ack;
        logic tx_done;
        logic tx_ready;
    } flags_t;

    typedef struct packed {
        logic              lock_en;
        logic [TADR_W-1:0] tgt;
    } cfg_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [TADR_W-1:0] a);
        return {a, 1'b0};
    endfunction

    function automatic logic scl_pull(input eng_state_t s, input logic [1:0] q);
        case (s)
            EN_START: return q == 2'd3;
            EN_SHIFT: return q < 2'd2;
            EN_STOP:  return q < 2'd2;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/i2cw_clkdiv.sv
module i2cw_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
    import i2cw_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              take,
    input  logic              nack_evt,
    input  logic              done_evt,
    output logic [BYTE_W-1:0] hold_byte,
    output logic              hold_full,
    output logic              go,
    output cfg_t              cfg,
    output logic [DIV_W-1:0]  div,
    output logic              irq,
    output logic              dma_req
);
    logic              tx_done, no_ack, locked;
    logic [FLAG_N-1:0] ien;
    flags_t            flags;
    logic              wr_data, rd_stat, unlock;

    assign wr_data = reg_wr && reg_addr == RA_DATA;
    assign rd_stat = reg_rd && reg_addr == RA_STAT;
    assign unlock  = reg_wr && reg_addr == RA_CMD && reg_wdata[0];

    assign flags   = '{locked: locked, no_ack: no_ack, tx_done: tx_done, tx_ready: !hold_full};
    assign go      = hold_full && !locked;
    assign dma_req = flags.tx_ready;
    assign irq     = |(flags & ien);

    always_comb begin
        case (reg_addr)
            RA_CFG:  reg_rdata = cfg;
            RA_DIV:  reg_rdata = BYTE_W'(div);
            RA_STAT: reg_rdata = BYTE_W'(flags);
            RA_IEN:  reg_rdata = BYTE_W'(ien);
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            div       <= DIV_W'(DIV_INIT);
            ien       <= '0;
            hold_byte <= '0;
            hold_full <= 1'b0;
            tx_done   <= 1'b1;
            no_ack    <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_CFG) cfg <= reg_wdata;
            if (reg_wr && reg_addr == RA_DIV) div <= DIV_W'(reg_wdata);
            if (reg_wr && reg_addr == RA_IEN) ien <= reg_wdata[FLAG_N-1:0];
            if (nack_evt) begin
                // all three flags together; a waiting byte is dropped
                no_ack    <= 1'b1;
                tx_done   <= 1'b1;
                hold_full <= 1'b0;
                if (cfg.lock_en) locked <= 1'b1;
            end else begin
                if (take) hold_full <= 1'b0;
                if (done_evt) tx_done <= 1'b1;
                if (wr_data && !locked) begin
                    hold_byte <= reg_wdata;
                    hold_full <= 1'b1;
                    tx_done   <= 1'b0;
                end
                if (rd_stat) no_ack <= 1'b0;
                if (unlock) locked <= 1'b0;
            end
        end
    end

    a_r5_flags_together: assert property (@(posedge clk) disable iff (rst)
        nack_evt |=> (no_ack && tx_done && dma_req));
    a_r7_lock_on_fail: assert property (@(posedge clk) disable iff (rst)
        (nack_evt && cfg.lock_en) |=> locked);
    a_r8_locked_absorbs: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_data) |=> dma_req);
    a_r9_unlock_clears: assert property (@(posedge clk) disable iff (rst)
        (unlock && !nack_evt) |=> !locked);
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !nack_evt) |=> !no_ack);
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  logic              avail,
    input  logic [BYTE_W-1:0] hold_byte,
    input  logic [TADR_W-1:0] tgt,
    input  logic              sda_in,
    output logic              take,
    output logic              nack_evt,
    output logic              done_evt,
    output logic              scl_low,
    output logic              sda_low
);
    eng_state_t        st;
    logic [1:0]        q;
    logic [BIT_IW-1:0] bit_i;
    logic [BYTE_W-1:0] shf;
    logic              is_addr, nacked, sda_r;
    logic              ack_slot, slot_end;

    assign ack_slot = st == EN_SHIFT && bit_i == ACK_IDX;
    assign slot_end = tick && q == 2'd3;
    assign nack_evt = tick && ack_slot && q == 2'd2 && sda_in;
    assign take     = slot_end && ack_slot && !nacked && (is_addr || avail);
    assign done_evt = slot_end && st == EN_STOP && !nacked;
    assign scl_low  = scl_pull(st, q);
    assign sda_low  = sda_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            q       <= '0;
            bit_i   <= '0;
            shf     <= '0;
            is_addr <= 1'b0;
            nacked  <= 1'b0;
            sda_r   <= 1'b0;
        end else if (tick) begin
            q <= q + 2'd1;
            case (st)
                EN_IDLE: begin
                    q <= '0;
                    if (go) st <= EN_START;
                end
                EN_START: begin
                    if (q == 2'd0) sda_r <= 1'b1;
                    if (q == 2'd3) begin
                        st      <= EN_SHIFT;
                        shf     <= addr_byte(tgt);
                        bit_i   <= '0;
                        is_addr <= 1'b1;
                        nacked  <= 1'b0;
                    end
                end
                EN_SHIFT: begin
                    // data moves only in the second low quarter
                    if (q == 2'd0) sda_r <= ack_slot ? 1'b0 : !shf[BYTE_W-1];
                    if (q == 2'd2 && ack_slot) nacked <= sda_in;
                    if (q == 2'd3) begin
                        if (!ack_slot) begin
                            shf   <= shf << 1;
                            bit_i <= bit_i + 1'b1;
                        end else if (take) begin
                            shf     <= hold_byte;
                            bit_i   <= '0;
                            is_addr <= 1'b0;
                        end else begin
                            st <= EN_STOP;
                        end
                    end
                end
                EN_STOP: begin
                    if (q == 2'd0) sda_r <= 1'b1;
                    if (q == 2'd2) sda_r <= 1'b0;
                    if (q == 2'd3) st <= EN_IDLE;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    a_r13_sda_still_scl_high: assert property (@(posedge clk) disable iff (rst)
        (st == EN_SHIFT && $past(st) == EN_SHIFT && !scl_low && !$past(scl_low))
        |-> $stable(sda_low));
    a_r6_stop_after_fail: assert property (@(posedge clk) disable iff (rst)
        (ack_slot && nacked && slot_end) |=> st == EN_STOP);
    a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == EN_IDLE) |-> (!scl_low && !sda_low));
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              irq,
    output logic              dma_req
);
    logic              tick, take, nack_evt, done_evt, go, hold_full;
    logic [BYTE_W-1:0] hold_byte;
    logic [DIV_W-1:0]  div;
    cfg_t              cfg;

    i2cw_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .div(div), .tick(tick)
    );

    i2cw_regs #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .take(take), .nack_evt(nack_evt), .done_evt(done_evt),
        .hold_byte(hold_byte), .hold_full(hold_full), .go(go),
        .cfg(cfg), .div(div), .irq(irq), .dma_req(dma_req)
    );

    i2cw_engine u_eng (
        .clk(clk), .rst(rst), .tick(tick), .go(go), .avail(hold_full),
        .hold_byte(hold_byte), .tgt(cfg.tgt), .sda_in(sda_in),
        .take(take), .nack_evt(nack_evt), .done_evt(done_evt),
        .scl_low(scl_low), .sda_low(sda_low)
    );
endmodule

// File: tb/sim_i2c_tx_master.sv
module sim_i2c_tx_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sda_in, scl_low, sda_low, irq, dma_req;
    logic       tgt_low = 1'b0;

    int n_chk = 0, n_fail = 0;
    int starts = 0, stops = 0, bitcnt = 0, byte_idx = 0, rx_n = 0;
    int tgt_nack = 3, hi_cnt = 0, last_hi = 0;
    logic [7:0] sh = '0;
    logic [7:0] rx_log [0:31];
    logic prev_scl = 1'b1, prev_sda = 1'b1, prev_irq = 1'b0;
    logic done_flag = 1'b0;

    always #10 clk = ~clk;

    assign sda_in = !(sda_low || tgt_low);

    i2c_tx_master u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
        .irq(irq), .dma_req(dma_req)
    );

    // target model: watches the lines and answers in the acknowledge slot
    always @(negedge clk) begin
        logic scl, sda;
        scl = !scl_low;
        sda = sda_in;
        if (!rst) begin
            if (scl && prev_scl && prev_sda && !sda) begin
                starts++; bitcnt = 0; byte_idx = 0;
            end else if (scl && prev_scl && !prev_sda && sda) begin
                stops++;
            end
            if (scl && !prev_scl) begin
                hi_cnt = 1;
                if (bitcnt < 8) sh = {sh[6:0], sda};
                bitcnt++;
            end else if (scl) begin
                hi_cnt++;
            end
            if (!scl && prev_scl && bitcnt >= 1) begin
                last_hi = hi_cnt;
                if (bitcnt == 8) tgt_low = (tgt_nack != byte_idx);
                if (bitcnt == 9) begin
                    tgt_low = 1'b0;
                    rx_log[rx_n % 32] = sh;
                    rx_n++; byte_idx++; bitcnt = 0;
                end
            end
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R5 at the ports: first cycle of irq (ack-failure enabled only) must see dma_req
    always @(negedge clk) begin
        if (!rst && irq && !prev_irq && u_ien_fail_only) check("R5 ready with ack-failure", dma_req, 1);
        prev_irq = irq;
    end
    logic u_ien_fail_only = 1'b0;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_stops(input int target);
        int n = 0;
        while (stops < target && n < 6000) begin @(posedge clk); n++; end
        if (n >= 6000) check("STOP wait timeout", stops, target);
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    typedef struct packed {
        logic       alt;
        logic [6:0] addr;
        logic [7:0] d0;
        logic [7:0] d1;
        logic       two;
        logic [1:0] nack_at;   // 0 address, 1 first data, 2 second data, 3 none
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        {1'b0, 7'h50, 8'hA5, 8'h00, 1'b0, 2'd3},
        {1'b0, 7'h2B, 8'h3C, 8'hC3, 1'b1, 2'd3},
        {1'b0, 7'h7F, 8'h00, 8'h00, 1'b0, 2'd0},
        {1'b0, 7'h11, 8'hFF, 8'h81, 1'b1, 2'd1},
        {1'b0, 7'h01, 8'h5A, 8'h96, 1'b1, 2'd2},
        {1'b1, 7'h33, 8'h77, 8'h00, 1'b0, 2'd0}
    };

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(3'd3, d);
        check("R1 status after reset", d, 8'h03);
        check("R1 scl released", scl_low, 0);
        check("R1 sda released", sda_low, 0);
        check("R1 irq low", irq, 0);
        check("R4 dma_req at reset", dma_req, 1);

        wr(3'd1, 8'd3);
        wr(3'd4, 8'h04);
        u_ien_fail_only = 1'b1;

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int s0, r0, nexp;
            logic nk;
            t = VECS[v];
            rd(3'd3, d);                      // clear a pending failure
            wr(3'd0, {t.alt, t.addr});
            tgt_nack = t.nack_at;
            s0 = stops; r0 = rx_n;
            wr(3'd2, t.d0);
            check("R4 dma_req drops after write", dma_req, 0);
            if (t.two) begin
                int n = 0;
                while (!dma_req && n < 4000) begin @(posedge clk); n++; end
                wr(3'd2, t.d1);
            end
            wait_stops(s0 + 1);
            nk = (t.nack_at == 2'd0) || (t.nack_at == 2'd1) || (t.nack_at == 2'd2 && t.two);
            nexp = 1 + (t.nack_at == 2'd0 ? 0 : 1) +
                   ((t.two && t.nack_at != 2'd0 && t.nack_at != 2'd1) ? 1 : 0);
            check("R2/R3 one START per transfer (R13)", starts, s0 + 1);
            check("R2/R3 byte count", rx_n - r0, nexp);
            check("R2 address byte", rx_log[r0 % 32], {t.addr, 1'b0});
            if (nexp > 1) check("R2 first data byte", rx_log[(r0 + 1) % 32], t.d0);
            if (nexp > 2) check("R3 second data byte", rx_log[(r0 + 2) % 32], t.d1);
            check("R6 lines released after STOP", {scl_low, sda_low}, 0);
            rd(3'd3, d);
            check("R5/R7 status after transfer", d, {4'b0, t.alt && nk, nk, 2'b11});
            if (v == 0) check("R14 SCL high length", last_hi, 8);
        end

        // R8: locked write is absorbed
        begin
            int s0;
            s0 = starts;
            wr(3'd2, 8'hEE);
            repeat (400) @(negedge clk);
            check("R8 no START while locked", starts, s0);
            check("R8 ready stays high", dma_req, 1);
            rd(3'd3, d);
            check("R8 status locked", d, 8'h0B);
        end

        // R9: unlock then normal transfer
        begin
            int s0, r0;
            wr(3'd5, 8'h01);
            rd(3'd3, d);
            check("R9 lock cleared", d, 8'h03);
            tgt_nack = 3;
            s0 = stops; r0 = rx_n;
            wr(3'd2, 8'h42);
            wait_stops(s0 + 1);
            check("R9 address after unlock", rx_log[r0 % 32], {7'h33, 1'b0});
            check("R9 data after unlock", rx_log[(r0 + 1) % 32], 8'h42);
        end

        // R10: no lock option, retry after failure
        begin
            int s0, st0, r0;
            wr(3'd0, {1'b0, 7'h19});
            tgt_nack = 0;
            s0 = stops; st0 = starts;
            wr(3'd2, 8'h10);
            wait_stops(s0 + 1);
            tgt_nack = 3;
            r0 = rx_n;
            wr(3'd2, 8'h20);
            wait_stops(s0 + 2);
            check("R10 second START", starts, st0 + 2);
            check("R10 address resent", rx_log[r0 % 32], {7'h19, 1'b0});
            check("R10 data sent", rx_log[(r0 + 1) % 32], 8'h20);
            rd(3'd3, d);
            check("R10 never locked", d[3], 0);
        end

        // R11 / R12: pending while masked, read clears
        begin
            int s0;
            u_ien_fail_only = 1'b0;
            wr(3'd4, 8'h00);
            tgt_nack = 0;
            s0 = stops;
            wr(3'd2, 8'h33);
            wait_stops(s0 + 1);
            check("R12 irq masked", irq, 0);
            wr(3'd4, 8'h04);
            check("R12 irq enabled on pending failure", irq, 1);
            rd(3'd3, d);
            check("R11 failure pending while masked", d[2], 1);
            @(negedge clk);
            check("R12 irq drops after clear", irq, 0);
            rd(3'd3, d);
            check("R11 read cleared failure", d[2], 0);
            wr(3'd4, 8'h02);
            check("R12 irq on complete flag", irq, 1);
            wr(3'd4, 8'h00);
        end

        // R14: faster divider
        begin
            int s0;
            tgt_nack = 3;
            wr(3'd1, 8'd1);
            s0 = stops;
            wr(3'd2, 8'h6D);
            wait_stops(s0 + 1);
            check("R14 SCL high length div 1", last_hi, 4);
        end

        finish_run();
    end
endmodule